// File: doc/BRIEF.md
# Full-Duplex Codec Serial Transceiver

This block moves one data word per frame in each direction over a four-wire codec link: a bit clock, a frame sync, a transmit line and a receive line. The bit clock and frame sync come in from outside. The block samples them with its own system clock and detects their edges in that domain. When the frame sync rises, the block takes one word from a transmit FIFO and shifts it out MSB first. In parallel it shifts one word in from the receive line and writes it to a receive FIFO.

The word length, the bit-clock edge used for each direction and a one-bit slot delay are all set through static control inputs. The word length and slot delay are taken at each frame start. The FIFOs sit outside the block. The transmit side reads from a show-ahead FIFO through a one-cycle read strobe. The receive side writes through a one-cycle write strobe, gated by a full flag. The transmitter runs only while the receiver is enabled. The receiver can run on its own.

Top module: `codec_serial_xcvr`

## Requirements
- R1: While reset is held and in the first cycles after it is released, `tx_line`, `tx_rd`, `rx_wr` and `rx_overrun` are all 0.
- R2: `word_mode` sets the bits per word: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32. Bits travel MSB first in both directions. In the 8-bit and 16-bit modes, the word is taken from the low bits of `tx_data`. In those modes it is written right-aligned to `rx_data`, with the upper bits at 0.
- R3: In the 24-bit mode, `tx_data[31:8]` is sent and `tx_data[7:0]` is ignored. The received sample is written to `rx_data[31:8]`, with `rx_data[7:0]` set to 0.
- R4: With `clk_pol` = 0, bits are launched on the rising bit-clock edge and captured on the falling edge. With `clk_pol` = 1, these two edges are swapped.
- R5: A frame starts at a launch edge where `frame_sync` is 1 and was 0 at the previous launch edge. With `slot_delay` = 0, the first bit goes out at that edge. With `slot_delay` = 1, it goes out at the next launch edge.
- R6: With `tx_en` = 1 but `rx_en` = 0, no word is fetched (`tx_rd` stays 0) and `tx_line` stays 0.
- R7: If `tx_empty` = 1 at frame start, the whole word is sent as 0s and `tx_rd` is not raised.
- R8: At most one `tx_rd` pulse occurs per frame, and only at its start. A word written after the frame start goes out in the next frame.
- R9: After the last bit of a word, `tx_line` returns to 0 and no further bits are captured or fetched until the next frame start. Each frame produces exactly one `rx_wr` pulse.
- R10: If `rx_full` = 1 when a received word completes, the word is dropped with no `rx_wr` pulse and `rx_overrun` goes to 1. `rx_overrun` stays at 1 until `rx_en` goes to 0.
- R11: With `rx_en` = 1 and `tx_en` = 0, received words are still written, while `tx_line` stays 0 and `tx_rd` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; the frame sequencer runs only while this is 1 |
| tx_en | input | 1 | Transmitter enable; takes effect only together with `rx_en` |
| clk_pol | input | 1 | Bit-clock edge selection (R4) |
| slot_delay | input | 1 | Delays the first bit by one bit clock |
| word_mode | input | 2 | Word length code (R2) |
| bit_clk | input | 1 | Serial bit clock, sampled by `clk` |
| frame_sync | input | 1 | Frame sync, active high |
| rx_line | input | 1 | Serial receive data |
| tx_line | output | 1 | Serial transmit data |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_rd | output | 1 | Pops the transmit FIFO |
| rx_data | output | 32 | Received word |
| rx_wr | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_overrun | output | 1 | Sticky flag for a dropped receive word |

## Verification
The hardest case to reach from the ports is a transmit word that arrives after the frame has already started. The word must wait a whole frame, and the line must carry zeros in the meantime. The bench pushes a word into its FIFO model on the second launch edge of a frame, then checks two things: that frame must be all zeros with no fetch, and the following frame must carry the word. A related case keeps a word waiting in the FIFO while bit clocks run with no frame sync; it checks that nothing is fetched or captured until the next frame sync rises. Random frames then mix word lengths, polarities, slot delays and empty FIFOs.

// File: rtl/codec_xcvr_pkg.sv
package codec_xcvr_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        LEN_8  = 2'd0,
        LEN_16 = 2'd1,
        LEN_24 = 2'd2,
        LEN_32 = 2'd3
    } word_len_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_SHIFT
    } seq_state_e;

    // index of the final bit of a word of the given length
    function automatic logic [IDX_W-1:0] last_index(word_len_e m);
        return IDX_W'((int'(m) + 1) * BYTE_W - 1);
    endfunction

    // move the meaningful part of a FIFO word up to the MSB end
    function automatic logic [WORD_W-1:0] tx_align(logic [WORD_W-1:0] w, word_len_e m);
        case (m)
            LEN_8:   return {w[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
            LEN_16:  return {w[2*BYTE_W-1:0], {(WORD_W-2*BYTE_W){1'b0}}};
            LEN_24:  return {w[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
            default: return w;
        endcase
    endfunction

    // place an assembled shift value into FIFO word format
    function automatic logic [WORD_W-1:0] rx_pack(logic [WORD_W-1:0] s, word_len_e m);
        case (m)
            LEN_8:   return {{(WORD_W-BYTE_W){1'b0}}, s[BYTE_W-1:0]};
            LEN_16:  return {{(WORD_W-2*BYTE_W){1'b0}}, s[2*BYTE_W-1:0]};
            LEN_24:  return {s[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/codec_frame_timer.sv
module codec_frame_timer
    import codec_xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clk_pol,
    input  logic       slot_delay,
    input  logic [1:0] word_mode,
    input  logic       bit_clk,
    input  logic       frame_sync,
    output logic       frame_start,
    output logic       bit_launch,
    output logic       launch_edge,
    output logic       bit_sample,
    output logic       last_sample,
    output word_len_e  cur_mode
);

    typedef struct packed {
        logic             bclk_prev;
        logic             fs_prev;
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        word_len_e        mode;
    } timer_t;

    timer_t timer_d, timer_q;
    logic   rise, fall, launch, capture;

    always_comb begin
        rise    = bit_clk & ~timer_q.bclk_prev;
        fall    = ~bit_clk & timer_q.bclk_prev;
        launch  = clk_pol ? fall : rise;
        capture = clk_pol ? rise : fall;

        timer_d           = timer_q;
        timer_d.bclk_prev = bit_clk;
        frame_start       = 1'b0;
        bit_launch        = 1'b0;

        if (launch) begin
            timer_d.fs_prev = frame_sync;
        end

        if (!run) begin
            timer_d.state = SEQ_IDLE;
            timer_d.idx   = '0;
        end else if (launch) begin
            if (frame_sync && !timer_q.fs_prev) begin
                frame_start  = 1'b1;
                timer_d.mode = word_len_e'(word_mode);
                timer_d.idx  = '0;
                if (slot_delay) begin
                    timer_d.state = SEQ_WAIT;
                end else begin
                    timer_d.state = SEQ_SHIFT;
                    bit_launch    = 1'b1;
                end
            end else begin
                case (timer_q.state)
                    SEQ_WAIT: begin
                        timer_d.state = SEQ_SHIFT;
                        bit_launch    = 1'b1;
                    end
                    SEQ_SHIFT: begin
                        if (timer_q.idx == last_index(timer_q.mode)) begin
                            timer_d.state = SEQ_IDLE;
                        end else begin
                            timer_d.idx = timer_q.idx + 1'b1;
                            bit_launch  = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end

        launch_edge = launch & run;
        bit_sample  = run & capture & (timer_q.state == SEQ_SHIFT);
        last_sample = bit_sample & (timer_q.idx == last_index(timer_q.mode));
        cur_mode    = frame_start ? word_len_e'(word_mode) : timer_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '{bclk_prev: 1'b0, fs_prev: 1'b0, state: SEQ_IDLE,
                         idx: '0, mode: LEN_8};
        end else begin
            timer_q <= timer_d;
        end
    end

    assert_index_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q.state == SEQ_SHIFT) |-> (timer_q.idx <= last_index(timer_q.mode)));

    assert_idle_after_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_sample && !launch) |=> !bit_sample);

endmodule

// File: rtl/codec_tx_shift.sv
module codec_tx_shift
    import codec_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic              bit_launch,
    input  logic              launch_edge,
    input  word_len_e         cur_mode,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_rd,
    output logic              tx_line
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic              line;
    } tx_t;

    tx_t               tx_d, tx_q;
    logic [WORD_W-1:0] word_sel;

    always_comb begin
        tx_d     = tx_q;
        tx_rd    = 1'b0;
        word_sel = tx_q.shreg;

        if (!enable) begin
            tx_d.shreg = '0;
            tx_d.line  = 1'b0;
        end else begin
            if (frame_start) begin
                tx_rd    = !tx_empty;
                word_sel = tx_empty ? '0 : tx_align(tx_data, cur_mode);
            end
            if (bit_launch) begin
                tx_d.line  = word_sel[WORD_W-1];
                tx_d.shreg = {word_sel[WORD_W-2:0], 1'b0};
            end else begin
                tx_d.shreg = word_sel;
                if (launch_edge) begin
                    tx_d.line = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{shreg: '0, line: 1'b0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_line = tx_q.line;

    assert_line_low_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tx_line);

    assert_empty_sends_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && tx_empty) |=> !tx_line);

endmodule

// File: rtl/codec_rx_shift.sv
module codec_rx_shift
    import codec_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic              bit_sample,
    input  logic              last_sample,
    input  word_len_e         cur_mode,
    input  logic              rx_line,
    input  logic              rx_full,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_wr,
    output logic              rx_overrun
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] data;
        logic              wr;
        logic              ovr;
    } rx_t;

    rx_t               rx_d, rx_q;
    logic [WORD_W-1:0] shift_next;

    always_comb begin
        rx_d       = rx_q;
        rx_d.wr    = 1'b0;
        shift_next = {rx_q.shreg[WORD_W-2:0], rx_line};

        if (!enable) begin
            rx_d.shreg = '0;
            rx_d.ovr   = 1'b0;
        end else begin
            if (frame_start) begin
                rx_d.shreg = '0;
            end
            if (bit_sample) begin
                rx_d.shreg = shift_next;
                if (last_sample) begin
                    if (rx_full) begin
                        rx_d.ovr = 1'b1;
                    end else begin
                        rx_d.wr   = 1'b1;
                        rx_d.data = rx_pack(shift_next, cur_mode);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{shreg: '0, data: '0, wr: 1'b0, ovr: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data    = rx_q.data;
    assign rx_wr      = rx_q.wr;
    assign rx_overrun = rx_q.ovr;

    assert_no_write_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> $past(!rx_full));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_overrun) && $past(enable) && enable) |-> rx_overrun);

    assert_low_byte_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && $past(cur_mode) == LEN_24) |-> (rx_data[BYTE_W-1:0] == '0));

endmodule

// File: rtl/codec_serial_xcvr.sv
module codec_serial_xcvr
    import codec_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              clk_pol,
    input  logic              slot_delay,
    input  logic [1:0]        word_mode,
    input  logic              bit_clk,
    input  logic              frame_sync,
    input  logic              rx_line,
    output logic              tx_line,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_wr,
    input  logic              rx_full,
    output logic              rx_overrun
);

    logic      frame_start, bit_launch, launch_edge, bit_sample, last_sample;
    word_len_e cur_mode;
    logic      tx_run;

    assign tx_run = tx_en & rx_en;

    codec_frame_timer i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (rx_en),
        .clk_pol     (clk_pol),
        .slot_delay  (slot_delay),
        .word_mode   (word_mode),
        .bit_clk     (bit_clk),
        .frame_sync  (frame_sync),
        .frame_start (frame_start),
        .bit_launch  (bit_launch),
        .launch_edge (launch_edge),
        .bit_sample  (bit_sample),
        .last_sample (last_sample),
        .cur_mode    (cur_mode)
    );

    codec_tx_shift i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tx_run),
        .frame_start (frame_start),
        .bit_launch  (bit_launch),
        .launch_edge (launch_edge),
        .cur_mode    (cur_mode),
        .tx_data     (tx_data),
        .tx_empty    (tx_empty),
        .tx_rd       (tx_rd),
        .tx_line     (tx_line)
    );

    codec_rx_shift i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (rx_en),
        .frame_start (frame_start),
        .bit_sample  (bit_sample),
        .last_sample (last_sample),
        .cur_mode    (cur_mode),
        .rx_line     (rx_line),
        .rx_full     (rx_full),
        .rx_data     (rx_data),
        .rx_wr       (rx_wr),
        .rx_overrun  (rx_overrun)
    );

    assert_fetch_at_frame_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd |-> frame_start);

    assert_no_fetch_without_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en) |-> !tx_rd);

endmodule

// File: tb/test_codec_serial_xcvr.sv
module test_codec_serial_xcvr;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, tx_en = 1'b0, clk_pol = 1'b0, slot_delay = 1'b0;
    logic [1:0]  word_mode = 2'd0;
    logic        bit_clk = 1'b0, frame_sync = 1'b0, rx_line = 1'b0, rx_full = 1'b0;
    logic        tx_line, tx_rd, rx_wr, rx_overrun, tx_empty;
    logic [31:0] tx_data, rx_data;

    logic [31:0] txq [8];
    int unsigned wr_ptr = 0, rd_ptr = 0;
    int          rx_wr_cnt = 0, tx_rd_cnt = 0;
    logic [31:0] rx_got = '0;
    int          n_checks = 0, n_fail = 0;

    assign tx_empty = (wr_ptr == rd_ptr);
    assign tx_data  = txq[rd_ptr % 8];

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_serial_xcvr i_codec_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .clk_pol(clk_pol),
        .slot_delay(slot_delay), .word_mode(word_mode), .bit_clk(bit_clk),
        .frame_sync(frame_sync), .rx_line(rx_line), .tx_line(tx_line),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_rd(tx_rd), .rx_data(rx_data),
        .rx_wr(rx_wr), .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    always @(posedge clk) begin
        if (tx_rd) begin
            rd_ptr    <= rd_ptr + 1;
            tx_rd_cnt <= tx_rd_cnt + 1;
        end
        if (rx_wr) begin
            rx_got    <= rx_data;
            rx_wr_cnt <= rx_wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        txq[wr_ptr % 8] = w;
        wr_ptr = wr_ptr + 1;
    endtask

    function automatic logic ser_bit(logic [31:0] w, logic [1:0] m, int b);
        int len = (int'(m) + 1) * 8;
        if (m == 2'd2) return w[31-b];
        return w[len-1-b];
    endfunction

    function automatic logic [31:0] exp_rx(logic [31:0] w, logic [1:0] m);
        case (m)
            2'd0:    return w & 32'h0000_00FF;
            2'd1:    return w & 32'h0000_FFFF;
            2'd2:    return w & 32'hFFFF_FF00;
            default: return w;
        endcase
    endfunction

    task automatic run_frame(input logic [1:0] m, input bit dly, input bit pol,
                             input logic [31:0] rxw, input bit tx_has,
                             input logic [31:0] txw, input bit exp_wr,
                             input bit push_mid, input logic [31:0] midw,
                             input string tag);
        int   len    = (int'(m) + 1) * 8;
        int   tx_err = 0;
        int   wr0    = rx_wr_cnt;
        int   rd0    = tx_rd_cnt;
        logic lvl    = ~pol;
        @(negedge clk);
        word_mode  = m;
        slot_delay = dly;
        clk_pol    = pol;
        bit_clk    = ~lvl;
        frame_sync = 1'b0;
        rx_line    = 1'b0;
        repeat (HALF_BIT) @(negedge clk);
        for (int k = 0; k < len + int'(dly) + 2; k++) begin
            int   b      = k - int'(dly);
            bit   inw    = (b >= 0) && (b < len);
            logic expbit;
            bit_clk    = lvl;
            frame_sync = (k == 0);
            rx_line    = inw ? ser_bit(rxw, m, b) : 1'b0;
            if (push_mid && k == 1) push(midw);
            repeat (HALF_BIT) @(negedge clk);
            expbit = (tx_has && inw) ? ser_bit(txw, m, b) : 1'b0;
            if (tx_line !== expbit) tx_err++;
            bit_clk = ~lvl;
            repeat (HALF_BIT) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check(tx_err == 0, {tag, " tx bits"}, tx_err, 0);
        check((rx_wr_cnt - wr0) == int'(exp_wr), {tag, " rx write count"}, rx_wr_cnt - wr0, exp_wr);
        if (exp_wr) check(rx_got == exp_rx(rxw, m), {tag, " rx word"}, rx_got, exp_rx(rxw, m));
        check((tx_rd_cnt - rd0) == int'(tx_has), {tag, " fetch count"}, tx_rd_cnt - rd0, tx_has);
    endtask

    task automatic run_idle(input int nbits, input string tag);
        int   bad = 0;
        int   wr0 = rx_wr_cnt;
        int   rd0 = tx_rd_cnt;
        logic lvl = ~clk_pol;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            bit_clk    = lvl;
            frame_sync = 1'b0;
            rx_line    = k[0];
            repeat (HALF_BIT) @(negedge clk);
            if (tx_line !== 1'b0) bad++;
            bit_clk = ~lvl;
            repeat (HALF_BIT - 1) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check(bad == 0, {tag, " line idle"}, bad, 0);
        check(rx_wr_cnt == wr0, {tag, " no capture"}, rx_wr_cnt - wr0, 0);
        check(tx_rd_cnt == rd0, {tag, " no fetch"}, tx_rd_cnt - rd0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w, r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(tx_line == 1'b0 && tx_rd == 1'b0, "R1 outputs in reset", {tx_line, tx_rd}, 0);
        check(rx_wr == 1'b0 && rx_overrun == 1'b0, "R1 flags in reset", {rx_wr, rx_overrun}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_line == 1'b0 && rx_wr == 1'b0 && rx_overrun == 1'b0 && tx_rd == 1'b0,
              "R1 after release", {tx_line, rx_wr, rx_overrun, tx_rd}, 0);

        rx_en = 1'b1;
        tx_en = 1'b1;
        // R2 every word length, R3 low byte of a 24-bit sample dropped
        push(32'hA5C3_1E7B); run_frame(2'd0, 0, 0, 32'h1234_56C9, 1, 32'hA5C3_1E7B, 1, 0, 0, "R2 8-bit");
        push(32'h0F0F_B00C); run_frame(2'd1, 0, 0, 32'hFFFF_8E31, 1, 32'h0F0F_B00C, 1, 0, 0, "R2 16-bit");
        push(32'hC001_D0A5); run_frame(2'd2, 0, 0, 32'h9ABC_DEF7, 1, 32'hC001_D0A5, 1, 0, 0, "R3 24-bit");
        push(32'h8000_0001); run_frame(2'd3, 0, 0, 32'h7E81_42BD, 1, 32'h8000_0001, 1, 0, 0, "R2 32-bit");
        // R4 swapped edges, R5 slot delay
        push(32'h0000_3C96); run_frame(2'd1, 0, 1, 32'h0000_5AA5, 1, 32'h0000_3C96, 1, 0, 0, "R4 clk_pol 1");
        push(32'h0000_00D2); run_frame(2'd0, 1, 0, 32'h0000_0081, 1, 32'h0000_00D2, 1, 0, 0, "R5 delay pol 0");
        push(32'hF00D_CAFE); run_frame(2'd3, 1, 1, 32'h1357_9BDF, 1, 32'hF00D_CAFE, 1, 0, 0, "R5 delay pol 1");
        // R7 empty FIFO, R8 word written during the frame waits a frame
        run_frame(2'd1, 0, 0, 32'h0000_7777, 0, 0, 1, 0, 0, "R7 empty fifo");
        run_frame(2'd0, 0, 0, 32'h0000_0042, 0, 0, 1, 1, 32'h0000_00E7, "R8 mid-frame write");
        run_frame(2'd0, 0, 0, 32'h0000_0011, 1, 32'h0000_00E7, 1, 0, 0, "R8 next frame");
        // R9 bit clocks with no frame sync do nothing while a word waits
        push(32'h0000_9D2B);
        run_idle(12, "R9 no frame sync");
        run_frame(2'd1, 0, 0, 32'h0000_4321, 1, 32'h0000_9D2B, 1, 0, 0, "R9 word after wait");
        // R6 transmitter without receiver
        rx_en = 1'b0;
        push(32'h0000_00B4);
        run_frame(2'd0, 0, 0, 32'h0000_00FF, 0, 0, 0, 0, 0, "R6 tx without rx");
        rx_en = 1'b1;
        run_frame(2'd0, 0, 0, 32'h0000_0033, 1, 32'h0000_00B4, 1, 0, 0, "R6 word kept");
        // R11 receiver alone
        tx_en = 1'b0;
        push(32'h0000_6699);
        run_frame(2'd1, 1, 1, 32'h0000_C3A1, 0, 0, 1, 0, 0, "R11 rx only");
        tx_en = 1'b1;
        run_frame(2'd1, 0, 0, 32'h0000_0001, 1, 32'h0000_6699, 1, 0, 0, "R11 word kept");
        // R10 overrun
        rx_full = 1'b1;
        run_frame(2'd0, 0, 0, 32'h0000_005A, 0, 0, 0, 0, 0, "R10 full drop");
        check(rx_overrun == 1'b1, "R10 overrun set", rx_overrun, 1);
        rx_full = 1'b0;
        run_frame(2'd0, 0, 0, 32'h0000_00A7, 0, 0, 1, 0, 0, "R10 after full");
        check(rx_overrun == 1'b1, "R10 overrun sticky", rx_overrun, 1);
        @(negedge clk); rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check(rx_overrun == 1'b0, "R10 overrun cleared", rx_overrun, 0);
        rx_en = 1'b1;

        for (int i = 0; i < 40; i++) begin
            logic [1:0] m   = 2'($urandom % 4);
            bit         dly = bit'($urandom % 2);
            bit         pol = bit'($urandom % 2);
            bit         has = bit'($urandom % 3 != 0);
            w = $urandom;
            r = $urandom;
            if (has) push(w);
            run_frame(m, dly, pol, r, has, w, 1, 0, 0, "R2 random frame");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule